// File: doc/BRIEF.md
# Multi-Channel Converter Scan Sequencer

This block drives a successive-approximation converter that sits behind an eight-way analog multiplexer. A trigger starts a scan. The sequencer then visits every enabled channel in ascending index order. For each channel it holds the multiplexer and a sample strobe for that channel's own acquisition time, and it pulses a start strobe. It then waits for the converter's done handshake. Each result goes into a buffer register that belongs to that channel, where software can read it at any later time.

While one conversion is running, the multiplexer already shows the next channel. The next sample window therefore opens on the cycle after done, so a scan over many channels loses no cycles to switching. Each result is compared with a shared low/high window as soon as it arrives. A result outside the window sets a sticky per-channel status bit, and a masked OR of those bits forms the range interrupt at once. The last enabled channel of a scan produces an end-of-scan pulse and sets a sticky flag. A continuous bit makes the scan start again. A firmware mode converts one channel picked directly by a register field.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, every register reads 0, `busy`, `adc_sample`, `adc_start`, `eos_pulse` and `irq_range` are 0.
- R2: A trigger in scan mode (CTRL bit1 = 0) while the enable register (0x01, bit n = channel n) is zero is ignored: no sample window opens and `busy` stays 0.
- R3: A scan visits only enabled channels, in ascending order. In continuous mode it wraps from the highest enabled channel back to the lowest.
- R4: Each sample window keeps `adc_sample` high and `adc_mux` at the channel for T+1 cycles, where T is the channel's sample-time register at 0x08+ch. `adc_start` pulses during the last cycle of the window.
- R5: During a conversion, `adc_mux` already shows the next channel. When the scan continues, `adc_sample` is high on the cycle right after `adc_done`.
- R6: Each result is stored in that channel's buffer at address 0x10+ch, and the other channels' buffers are left unchanged.
- R7: A result below the low limit (0x03) or above the high limit (0x04) sets bit ch of the out-of-range status register (0x05) in the cycle after done. A result equal to either limit does not. `irq_range` is the OR of that status ANDed with the range-check enable register (0x02).
- R8: Writing 1 to a bit of 0x05 clears that bit, and writing 0 to a bit leaves it unchanged. If a new violation arrives in the same cycle as the clear, the set takes priority.
- R9: The conversion of the last enabled channel in a scan raises `eos_pulse` for one cycle and sets the scan-done flag (0x06 bit0). Writing 1 to that bit clears it.
- R10: With CTRL bit0 = 1, a new scan begins right after end-of-scan. With CTRL bit0 = 0, the sequencer goes idle. The continuous bit is read at end-of-scan.
- R11: With CTRL bit1 = 1, a trigger converts the channel held in CTRL bits 4:2 once, whatever the enables say. Each such conversion counts as a complete scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data, combinational from `reg_addr` |
| trig | input | 1 | Start a scan (ignored while busy) |
| adc_mux | output | 3 | Analog multiplexer select |
| adc_sample | output | 1 | Sample window active |
| adc_start | output | 1 | Conversion start strobe |
| adc_done | input | 1 | Conversion complete strobe |
| adc_data | input | 12 | Conversion result, valid with `adc_done` |
| eos_pulse | output | 1 | End-of-scan pulse |
| irq_range | output | 1 | Range-violation interrupt |
| busy | output | 1 | Sequencer not idle |

## Verification
The main scan is exercised with three enable patterns:
- A sparse four-channel set with unequal sample times. This separates correct ordering and per-channel window lengths from a sequencer that uses one shared time or visits disabled channels.
- A two-channel set in continuous mode. This exposes wrap and restart faults.
- An empty set. This catches a sequencer that starts with nothing to do.

The range test uses results just below, exactly at, and just above the limits, with only some channels masked. It shows that the interrupt rises after the first violating conversion rather than at end-of-scan, and that masking and write-one-to-clear act per bit. Firmware mode is checked with a channel that is disabled for scanning.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SEQ_NCH = 8;
  localparam int SEQ_CHW = $clog2(SEQ_NCH);
  localparam int SEQ_DW  = 12;
  localparam int SEQ_STW = 8;
  localparam int SEQ_AW  = 5;

  localparam logic [SEQ_AW-1:0] A_CTRL  = 5'h00;
  localparam logic [SEQ_AW-1:0] A_CHEN  = 5'h01;
  localparam logic [SEQ_AW-1:0] A_RNGEN = 5'h02;
  localparam logic [SEQ_AW-1:0] A_LO    = 5'h03;
  localparam logic [SEQ_AW-1:0] A_HI    = 5'h04;
  localparam logic [SEQ_AW-1:0] A_OOR   = 5'h05;
  localparam logic [SEQ_AW-1:0] A_STAT  = 5'h06;

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CONV} seq_state_t;

  // Lowest enabled index at or above 'from', wrapping modulo SEQ_NCH.
  function automatic logic [SEQ_CHW-1:0] seq_pick(input logic [SEQ_NCH-1:0] en,
                                                  input logic [SEQ_CHW-1:0] from);
    logic [SEQ_CHW-1:0] idx;
    logic [SEQ_CHW-1:0] r;
    r = from;
    for (int k = SEQ_NCH - 1; k >= 0; k--) begin
      idx = from + k[SEQ_CHW-1:0];
      if (en[idx]) r = idx;
    end
    return r;
  endfunction

  // True when a result lies strictly outside the [lo, hi] window.
  function automatic logic seq_outside(input logic [SEQ_DW-1:0] v,
                                       input logic [SEQ_DW-1:0] lo,
                                       input logic [SEQ_DW-1:0] hi);
    return (v < lo) || (v > hi);
  endfunction
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH = SEQ_NCH,
  parameter int CHW = SEQ_CHW,
  parameter int STW = SEQ_STW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig,
  input  logic                     fw_mode,
  input  logic [CHW-1:0]           fw_ch,
  input  logic                     cont,
  input  logic [NCH-1:0]           chen,
  input  logic [NCH-1:0][STW-1:0]  stime,
  input  logic                     adc_done,
  output logic [CHW-1:0]           adc_mux,
  output logic                     adc_sample,
  output logic                     adc_start,
  output logic                     busy,
  output logic                     done_evt,
  output logic [CHW-1:0]           done_ch,
  output logic                     eos
);
  seq_state_t     st_q;
  logic [CHW-1:0] cur_q;
  logic [STW-1:0] cnt_q;
  logic [CHW-1:0] first_ch, nxt_ch;
  logic           any_en, last_ch;

  always_comb begin
    any_en     = |chen;
    first_ch   = fw_mode ? fw_ch : seq_pick(chen, '0);
    nxt_ch     = fw_mode ? fw_ch : seq_pick(chen, CHW'(cur_q + 1'b1));
    last_ch    = fw_mode || !any_en || (nxt_ch <= cur_q);
    done_evt   = (st_q == S_CONV) && adc_done;
    eos        = done_evt && last_ch;
    adc_sample = (st_q == S_SAMP);
    adc_start  = (st_q == S_SAMP) && (cnt_q == '0);
    adc_mux    = (st_q == S_CONV) ? nxt_ch : cur_q;
    busy       = (st_q != S_IDLE);
    done_ch    = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cur_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (trig && (fw_mode || any_en)) begin
          st_q  <= S_SAMP;
          cur_q <= first_ch;
          cnt_q <= stime[first_ch];
        end
        S_SAMP: if (cnt_q == '0) st_q <= S_CONV;
                else             cnt_q <= cnt_q - 1'b1;
        S_CONV: if (adc_done) begin
          if ((last_ch && !cont) || (!fw_mode && !any_en)) begin
            st_q <= S_IDLE;
          end else begin
            st_q  <= S_SAMP;
            cur_q <= nxt_ch;
            cnt_q <= stime[nxt_ch];
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_start_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> adc_sample);
  p_mux_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sample && !adc_start) |=> (adc_sample && $stable(adc_mux)));
  p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !eos) |=> adc_sample);
  p_mux_lookahead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !eos) |=> (adc_mux == $past(adc_mux)));
  p_empty_trig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && !fw_mode && chen == '0) |=> !busy);
  p_idle_after_eos_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !cont) |=> !busy);
endmodule

// File: rtl/seq_regs.sv
module seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NCH = SEQ_NCH,
  parameter int CHW = SEQ_CHW,
  parameter int DW  = SEQ_DW,
  parameter int STW = SEQ_STW,
  parameter int AW  = SEQ_AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [AW-1:0]            reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic                     done_evt,
  input  logic [CHW-1:0]           done_ch,
  input  logic [DW-1:0]            adc_data,
  input  logic                     eos,
  output logic                     cont,
  output logic                     fw_mode,
  output logic [CHW-1:0]           fw_ch,
  output logic [NCH-1:0]           chen,
  output logic [NCH-1:0][STW-1:0]  stime,
  output logic                     irq_range
);
  localparam int CW = 2 + CHW;

  logic [CW-1:0]           ctrl_q;
  logic [NCH-1:0]          chen_q, rngen_q, oor_q, oor_set;
  logic [DW-1:0]           lo_q, hi_q;
  logic                    sdone_q;
  logic [NCH-1:0][STW-1:0] stime_q;
  logic [NCH-1:0][DW-1:0]  res_q;
  logic                    hit, wr_oor, wr_stat;

  assign hit     = done_evt && seq_outside(adc_data, lo_q, hi_q);
  assign oor_set = hit ? (NCH'(1) << done_ch) : '0;
  assign wr_oor  = reg_wr && (reg_addr == A_OOR);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      chen_q  <= '0;
      rngen_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      oor_q   <= '0;
      sdone_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        unique case (reg_addr)
          A_CTRL:  ctrl_q  <= reg_wdata[CW-1:0];
          A_CHEN:  chen_q  <= reg_wdata[NCH-1:0];
          A_RNGEN: rngen_q <= reg_wdata[NCH-1:0];
          A_LO:    lo_q    <= reg_wdata;
          A_HI:    hi_q    <= reg_wdata;
          default: ;
        endcase
      end
      oor_q   <= (oor_q & ~(wr_oor ? reg_wdata[NCH-1:0] : '0)) | oor_set;
      sdone_q <= (sdone_q & ~(wr_stat && reg_wdata[0])) | eos;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stime_q[g] <= '0;
        res_q[g]   <= '0;
      end else begin
        if (reg_wr && reg_addr == AW'(8 + g)) stime_q[g] <= reg_wdata[STW-1:0];
        if (done_evt && done_ch == CHW'(g))   res_q[g]   <= adc_data;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:  reg_rdata = DW'(ctrl_q);
      A_CHEN:  reg_rdata = DW'(chen_q);
      A_RNGEN: reg_rdata = DW'(rngen_q);
      A_LO:    reg_rdata = lo_q;
      A_HI:    reg_rdata = hi_q;
      A_OOR:   reg_rdata = DW'(oor_q);
      A_STAT:  reg_rdata = DW'(sdone_q);
      default: begin
        if (reg_addr[4:3] == 2'b01) reg_rdata = DW'(stime_q[reg_addr[CHW-1:0]]);
        if (reg_addr[4:3] == 2'b10) reg_rdata = res_q[reg_addr[CHW-1:0]];
      end
    endcase
  end

  assign cont      = ctrl_q[0];
  assign fw_mode   = ctrl_q[1];
  assign fw_ch     = ctrl_q[CW-1:2];
  assign chen      = chen_q;
  assign stime     = stime_q;
  assign irq_range = |(oor_q & rngen_q);

  p_masked_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rngen_q[done_ch] && !(reg_wr && reg_addr == A_RNGEN)) |=> irq_range);
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_oor && !done_evt) |=> ((oor_q & $past(reg_wdata[NCH-1:0])) == '0));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (oor_q != '0));
  p_sdone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eos |=> sdone_q);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH = SEQ_NCH,
  parameter int DW  = SEQ_DW,
  parameter int STW = SEQ_STW,
  parameter int AW  = SEQ_AW,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           trig,
  output logic [CHW-1:0] adc_mux,
  output logic           adc_sample,
  output logic           adc_start,
  input  logic           adc_done,
  input  logic [DW-1:0]  adc_data,
  output logic           eos_pulse,
  output logic           irq_range,
  output logic           busy
);
  logic                    cont, fw_mode, done_evt;
  logic [CHW-1:0]          fw_ch, done_ch;
  logic [NCH-1:0]          chen;
  logic [NCH-1:0][STW-1:0] stime;

  seq_regs #(.NCH(NCH), .CHW(CHW), .DW(DW), .STW(STW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_evt(done_evt),
    .done_ch(done_ch), .adc_data(adc_data), .eos(eos_pulse), .cont(cont),
    .fw_mode(fw_mode), .fw_ch(fw_ch), .chen(chen), .stime(stime),
    .irq_range(irq_range)
  );

  seq_ctrl #(.NCH(NCH), .CHW(CHW), .STW(STW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .fw_mode(fw_mode), .fw_ch(fw_ch),
    .cont(cont), .chen(chen), .stime(stime), .adc_done(adc_done),
    .adc_mux(adc_mux), .adc_sample(adc_sample), .adc_start(adc_start),
    .busy(busy), .done_evt(done_evt), .done_ch(done_ch), .eos(eos_pulse)
  );

  p_eos_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eos_pulse |=> !eos_pulse);
endmodule

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;
  localparam int CONV_LAT = 18;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, trig = 1'b0, adc_done = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0, adc_data = '0, reg_rdata;
  logic [2:0]  adc_mux;
  logic        adc_sample, adc_start, eos_pulse, irq_range, busy;

  adc_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig),
    .adc_mux(adc_mux), .adc_sample(adc_sample), .adc_start(adc_start),
    .adc_done(adc_done), .adc_data(adc_data), .eos_pulse(eos_pulse),
    .irq_range(irq_range), .busy(busy)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int chdata [8];
  int log_ch [64], log_len [64], done_mux [64];
  int post_smp [64], post_mux [64], post_irq [64];
  int nlog = 0, ndone = 0, npost = 0, eos_cnt = 0, run = 0;
  bit prev_done = 0;
  int conv_cnt = 0, conv_ch = 0;

  // Converter model: done arrives CONV_LAT cycles after start.
  always @(negedge clk) begin
    if (!rst_n) begin
      conv_cnt = 0; adc_done = 1'b0;
    end else begin
      adc_done = 1'b0;
      if (conv_cnt != 0) begin
        conv_cnt--;
        if (conv_cnt == 0) begin adc_done = 1'b1; adc_data = 12'(chdata[conv_ch]); end
      end
      if (adc_start) begin conv_cnt = CONV_LAT; conv_ch = int'(adc_mux); end
    end
  end

  // Monitor, sampled 1 ns after the falling edge.
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (prev_done && npost < 64) begin
        post_smp[npost] = int'(adc_sample); post_mux[npost] = int'(adc_mux);
        post_irq[npost] = int'(irq_range); npost++;
      end
      if (adc_done && ndone < 64) begin
        done_mux[ndone] = int'(adc_mux); ndone++;
        if (eos_pulse) eos_cnt++;
      end
      prev_done = adc_done;
      if (adc_sample) run++;
      if (adc_start && nlog < 64) begin
        log_ch[nlog] = int'(adc_mux); log_len[nlog] = run; nlog++; run = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 12'(d);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = 5'(a); #1; d = int'(reg_rdata);
  endtask

  task automatic clr_log();
    nlog = 0; ndone = 0; npost = 0; eos_cnt = 0; run = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if (!busy) break;
    end
  endtask

  task automatic t_reset();
    int v;
    chk("R1 busy", int'(busy), 0);
    chk("R1 sample", int'(adc_sample), 0);
    chk("R1 irq", int'(irq_range), 0);
    rd(1, v);    chk("R1 chen", v, 0);
    rd(5, v);    chk("R1 oor", v, 0);
    rd(5'h13, v); chk("R1 result3", v, 0);
  endtask

  task automatic t_empty();
    clr_log();
    wr(0, 0); wr(1, 0);
    pulse_trig();
    repeat (10) @(negedge clk);
    #1;
    chk("R2 busy after empty trigger", int'(busy), 0);
    chk("R2 no window", nlog, 0);
  endtask

  task automatic t_scan();
    int v;
    int exp_ch [4] = '{0, 2, 5, 7};
    int exp_t  [4] = '{0, 3, 1, 6};
    clr_log();
    for (int i = 0; i < 8; i++) chdata[i] = 100 * i + 7;
    wr(3, 0); wr(4, 4095);
    for (int i = 0; i < 4; i++) wr(8 + exp_ch[i], exp_t[i]);
    wr(1, 8'hA5); wr(0, 0);
    pulse_trig(); wait_idle();
    chk("R3 visit count", nlog, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 order", log_ch[i], exp_ch[i]);
      chk("R4 window length", log_len[i], exp_t[i] + 1);
    end
    for (int i = 0; i < 3; i++) begin
      chk("R5 lookahead mux", done_mux[i], exp_ch[i + 1]);
      chk("R5 no gap", post_smp[i], 1);
      chk("R5 mux after done", post_mux[i], exp_ch[i + 1]);
    end
    chk("R10 idle after single scan", post_smp[3], 0);
    for (int i = 0; i < 4; i++) begin
      rd(16 + exp_ch[i], v); chk("R6 buffer", v, chdata[exp_ch[i]]);
    end
    rd(16 + 1, v); chk("R6 disabled buffer untouched", v, 0);
    chk("R9 one eos", eos_cnt, 1);
    rd(6, v); chk("R9 scan-done set", v, 1);
    wr(6, 1); rd(6, v); chk("R9 scan-done cleared", v, 0);
  endtask

  task automatic t_range();
    int v;
    clr_log();
    chdata[1] = 99; chdata[3] = 100; chdata[4] = 3001; chdata[6] = 3000;
    wr(3, 100); wr(4, 3000); wr(2, 8'h02);
    wr(8 + 1, 0); wr(8 + 3, 0); wr(8 + 4, 0); wr(8 + 6, 0);
    wr(1, 8'h5A);
    chk("R7 irq low before scan", int'(irq_range), 0);
    pulse_trig(); wait_idle();
    chk("R7 irq right after first violation", post_irq[0], 1);
    rd(5, v); chk("R7 status bits", v, 8'h12);
    chk("R7 irq level", int'(irq_range), 1);
    wr(5, 8'h02); rd(5, v); chk("R8 w1c clears bit1 only", v, 8'h10);
    #1; chk("R7 masked ch4 no irq", int'(irq_range), 0);
    wr(2, 8'h10); #1; chk("R7 enable ch4 irq", int'(irq_range), 1);
    wr(5, 8'h00); rd(5, v); chk("R8 writing 0 keeps bits", v, 8'h10);
    wr(5, 8'hFF); rd(5, v); chk("R8 clear all", v, 0);
    wr(2, 0);
  endtask

  task automatic t_cont();
    clr_log();
    wr(8 + 1, 0); wr(8 + 6, 0);
    wr(1, 8'h42); wr(0, 1);
    pulse_trig();
    for (int i = 0; i < 2000 && eos_cnt < 3; i++) @(negedge clk);
    wr(0, 0); wait_idle();
    chk("R10 continuous restarted", int'(eos_cnt >= 3), 1);
    chk("R10 whole scans", nlog % 2, 0);
    chk("R10 eos per scan", eos_cnt, nlog / 2);
    for (int i = 0; i < nlog && i < 64; i++)
      chk("R3 wrap order", log_ch[i], (i % 2 == 0) ? 1 : 6);
    chk("R10 idle after clearing", int'(busy), 0);
  endtask

  task automatic t_fw();
    int v;
    clr_log();
    chdata[3] = 12'h5C3;
    wr(1, 0); wr(0, 2 | (3 << 2));
    pulse_trig(); wait_idle();
    chk("R11 one conversion", nlog, 1);
    chk("R11 channel", log_ch[0], 3);
    rd(16 + 3, v); chk("R11 result", v, 12'h5C3);
    chk("R11 counts as scan", eos_cnt, 1);
    wr(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) chdata[i] = 0;
    repeat (3) @(negedge clk);
    #1; t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_empty();
    t_scan();
    t_range();
    t_cont();
    t_fw();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule